// File: doc/BRIEF.md
# Synchronous Half-Duplex Byte Shifter

This block moves 8-bit bytes over a two-wire synchronous link where it is the clock master. One bidirectional data line carries the bits in both directions, least significant bit first. The second line carries a shift clock that the block generates itself. That clock idles high. Each bit gets one low pulse, and the partner device uses its edges to take or present data.

A one-cycle write strobe starts a transmit frame. Receive frames start on their own whenever reception is enabled, the receive-done flag is clear and the port is idle. A speed select picks a bit period of 12 system clocks (slow) or 4 system clocks (fast). The position and width of the clock low pulse inside the bit period follow the speed. Completion is reported through sticky transmit-done and receive-done flags. Software clears each flag with its own one-cycle pulse.

The block presents the data line as separate drive value, output enable and input. The pad and the partner device sit outside.

Top module: `ssp_sync_port`

## Requirements
- R1: After reset the shift clock is high, the data output enable is low, both done flags are 0 and the receive buffer is 0.
- R2: A write strobe while idle starts a transmit frame. Bit k of the written byte (k = 0 first) is driven during the k-th bit period, and the output enable stays high through all 8 periods.
- R3: The bit period is 12 clocks when the speed input is 0 and 4 clocks when it is 1. The speed is captured when a frame starts, and changing it during a frame has no effect on that frame.
- R4: Within each bit period the data changes first. The shift clock falls 3 clocks later (slow) or 1 clock later (fast). It then stays low for 6 clocks (slow) or 2 clocks (fast), and it is high for the rest of the period. The shift clock is high whenever no frame is active.
- R5: The transmit-done flag rises in the first cycle after the eighth bit period ends. The output enable drops in that same cycle.
- R6: A receive frame starts when receive enable is 1, receive-done is 0, the port is idle and no write strobe is present. The output enable stays low. The data input is sampled on each rising shift-clock edge, and the k-th sample becomes bit k of the byte. Receive-done and the receive buffer update in the cycle after the eighth rising edge.
- R7: While receive-done is 1, no receive frame starts, and the shift clock stays high.
- R8: If a write strobe and a receive start condition occur in the same cycle, the transmit frame runs.
- R9: A write strobe during an active frame is ignored, and the frame in progress keeps its byte.
- R10: A clear pulse resets its flag. If a flag is set in the same cycle as its clear pulse, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_fast_i | input | 1 | 0: 12-clock bit period, 1: 4-clock bit period |
| rx_en_i | input | 1 | Receive enable |
| tx_wr_i | input | 1 | One-cycle write strobe starting a transmit |
| tx_data_i | input | 8 | Byte to transmit, taken with the strobe |
| tx_done_clr_i | input | 1 | Clears the transmit-done flag |
| rx_done_clr_i | input | 1 | Clears the receive-done flag |
| sdat_i | input | 1 | Data line value seen at the pad |
| sdat_o | output | 1 | Data line drive value |
| sdat_oe_o | output | 1 | Data line drive enable (high only while transmitting) |
| sclk_o | output | 1 | Generated shift clock |
| rx_data_o | output | 8 | Last received byte |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
During receive, the bench presents the right bit on the data input only in the single cycle before each rising shift-clock edge and the inverted bit at every other time. A design that samples one cycle early or late, or on the falling edge, therefore collects a corrupted byte. Transmit frames are compared cycle by cycle against a computed clock waveform in both speeds, so a wrong lead, low width or period shows up as a mismatch. Directed cases flip the speed input and write a second byte in mid-frame; a design that does not hold its captured values corrupts the frame. Further directed cases raise the write strobe together with receive enable, hold receive enable high while receive-done is set, and clear a flag in the very cycle it is set. A wrong priority drops the output enable, a missing block starts an unwanted receive, and a clear that wins loses the completion.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } ssp_state_e;

endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
    parameter int SLOW_DIV  = 12,
    parameter int FAST_DIV  = 4,
    parameter int SLOW_LEAD = 3,
    parameter int FAST_LEAD = 1,
    parameter int SLOW_LOW  = 6,
    parameter int FAST_LOW  = 2,
    parameter int NBITS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic sclk_low_o,
    output logic sample_o,
    output logic bit_end_o,
    output logic last_bit_o
);
    localparam int MAXDIV  = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PHASE_W = $clog2(MAXDIV);
    localparam int BIT_W   = (NBITS > 1) ? $clog2(NBITS) : 1;

    localparam logic [PHASE_W-1:0] S_LAST  = PHASE_W'(SLOW_DIV - 1);
    localparam logic [PHASE_W-1:0] F_LAST  = PHASE_W'(FAST_DIV - 1);
    localparam logic [PHASE_W-1:0] S_FALL  = PHASE_W'(SLOW_LEAD);
    localparam logic [PHASE_W-1:0] F_FALL  = PHASE_W'(FAST_LEAD);
    localparam logic [PHASE_W-1:0] S_RISE  = PHASE_W'(SLOW_LEAD + SLOW_LOW);
    localparam logic [PHASE_W-1:0] F_RISE  = PHASE_W'(FAST_LEAD + FAST_LOW);
    localparam logic [BIT_W-1:0]   LASTBIT = BIT_W'(NBITS - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [BIT_W-1:0]   bitn;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    logic [PHASE_W-1:0] per_last, fall_at, rise_at;

    always_comb begin
        per_last = fast_i ? F_LAST : S_LAST;
        fall_at  = fast_i ? F_FALL : S_FALL;
        rise_at  = fast_i ? F_RISE : S_RISE;

        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.phase = '0;
            tmr_d.bitn  = '0;
        end else if (tmr_q.phase == per_last) begin
            tmr_d.phase = '0;
            tmr_d.bitn  = tmr_q.bitn + 1'b1;
        end else begin
            tmr_d.phase = tmr_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign sclk_low_o = run_i && (tmr_q.phase >= fall_at) && (tmr_q.phase < rise_at);
    assign sample_o   = run_i && (tmr_q.phase == rise_at - 1'b1);
    assign bit_end_o  = run_i && (tmr_q.phase == per_last);
    assign last_bit_o = (tmr_q.bitn == LASTBIT);

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.phase <= per_last);

    // R4
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tmr_q.phase == '0));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         ser_i,
    output logic [W-1:0] par_o
);
    typedef struct packed {
        logic [W-1:0] sh;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i)       shf_d.sh = load_val_i;
        else if (shift_i) shf_d.sh = {ser_i, shf_q.sh[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign par_o = shf_q.sh;

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (par_o == $past(load_val_i)));

endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port
    import ssp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SLOW_DIV  = 12,
    parameter int FAST_DIV  = 4,
    parameter int SLOW_LEAD = 3,
    parameter int FAST_LEAD = 1,
    parameter int SLOW_LOW  = 6,
    parameter int FAST_LOW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_fast_i,
    input  logic              rx_en_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_done_clr_i,
    input  logic              rx_done_clr_i,
    input  logic              sdat_i,
    output logic              sdat_o,
    output logic              sdat_oe_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              tx_done_o,
    output logic              rx_done_o
);
    typedef struct packed {
        ssp_state_e        state;
        logic              fast;
        logic              tx_done;
        logic              rx_done;
        logic [DATA_W-1:0] rx_buf;
    } port_t;

    port_t port_d, port_q;

    logic              run, sclk_low, sample, bit_end, last_bit;
    logic              start_tx, start_rx, tx_finish, rx_finish, do_shift;
    logic [DATA_W-1:0] sh_par;

    ssp_bit_timer #(
        .SLOW_DIV (SLOW_DIV),  .FAST_DIV (FAST_DIV),
        .SLOW_LEAD(SLOW_LEAD), .FAST_LEAD(FAST_LEAD),
        .SLOW_LOW (SLOW_LOW),  .FAST_LOW (FAST_LOW),
        .NBITS    (DATA_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .fast_i    (port_q.fast),
        .sclk_low_o(sclk_low),
        .sample_o  (sample),
        .bit_end_o (bit_end),
        .last_bit_o(last_bit)
    );

    ssp_shifter #(.W(DATA_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_tx),
        .load_val_i(tx_data_i),
        .shift_i   (do_shift),
        .ser_i     (sdat_i),
        .par_o     (sh_par)
    );

    always_comb begin
        run       = (port_q.state != ST_IDLE);
        start_tx  = (port_q.state == ST_IDLE) && tx_wr_i;
        start_rx  = (port_q.state == ST_IDLE) && !tx_wr_i && rx_en_i && !port_q.rx_done;
        tx_finish = (port_q.state == ST_TX) && bit_end && last_bit;
        rx_finish = (port_q.state == ST_RX) && sample && last_bit;
        do_shift  = ((port_q.state == ST_TX) && bit_end) ||
                    ((port_q.state == ST_RX) && sample);

        port_d = port_q;
        case (port_q.state)
            ST_IDLE: begin
                if (start_tx) begin
                    port_d.state = ST_TX;
                    port_d.fast  = speed_fast_i;
                end else if (start_rx) begin
                    port_d.state = ST_RX;
                    port_d.fast  = speed_fast_i;
                end
            end
            ST_TX: if (tx_finish) port_d.state = ST_IDLE;
            ST_RX: if (rx_finish) begin
                port_d.state  = ST_IDLE;
                port_d.rx_buf = {sdat_i, sh_par[DATA_W-1:1]};
            end
            default: port_d.state = ST_IDLE;
        endcase

        port_d.tx_done = (port_q.tx_done && !tx_done_clr_i) || tx_finish;
        port_d.rx_done = (port_q.rx_done && !rx_done_clr_i) || rx_finish;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q       <= '0;
            port_q.state <= ST_IDLE;
        end else begin
            port_q <= port_d;
        end
    end

    assign sdat_o    = sh_par[0];
    assign sdat_oe_o = (port_q.state == ST_TX);
    assign sclk_o    = !sclk_low;
    assign rx_data_o = port_q.rx_buf;
    assign tx_done_o = port_q.tx_done;
    assign rx_done_o = port_q.rx_done;

    // R3
    speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q.state != ST_IDLE && $past(port_q.state) != ST_IDLE) |-> $stable(port_q.fast));

    // R4
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q.state == ST_IDLE) |-> sclk_o);

    // R5
    tx_done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_o) |-> ($past(port_q.state) == ST_TX && !sdat_oe_o));

    // R7
    rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q.state == ST_IDLE && port_q.rx_done) |=> (port_q.state != ST_RX));

    // R8
    tx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q.state == ST_IDLE && tx_wr_i) |=> (port_q.state == ST_TX));

endmodule

// File: tb/ssp_sync_port_tb.sv
module ssp_sync_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_fast_i = 1'b0;
    logic       rx_en_i = 1'b0;
    logic       tx_wr_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic       tx_done_clr_i = 1'b0;
    logic       rx_done_clr_i = 1'b0;
    logic       sdat_i = 1'b1;
    logic       sdat_o, sdat_oe_o, sclk_o, tx_done_o, rx_done_o;
    logic [7:0] rx_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ssp_sync_port dut_i (
        .clk(clk), .rst_n(rst_n), .speed_fast_i(speed_fast_i), .rx_en_i(rx_en_i),
        .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .tx_done_clr_i(tx_done_clr_i),
        .rx_done_clr_i(rx_done_clr_i), .sdat_i(sdat_i), .sdat_o(sdat_o),
        .sdat_oe_o(sdat_oe_o), .sclk_o(sclk_o), .rx_data_o(rx_data_o),
        .tx_done_o(tx_done_o), .rx_done_o(rx_done_o)
    );

    function automatic int per_of(bit f);  return f ? 4 : 12; endfunction
    function automatic int lead_of(bit f); return f ? 1 : 3;  endfunction
    function automatic int low_of(bit f);  return f ? 2 : 6;  endfunction
    function automatic logic exp_sclk(int ph, bit f);
        return !((ph >= lead_of(f)) && (ph < lead_of(f) + low_of(f)));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_clear_tx();
        @(negedge clk); tx_done_clr_i = 1'b1;
        @(negedge clk); tx_done_clr_i = 1'b0;
        check("R10 tx clear", tx_done_o, 0);
    endtask

    // Transmit one frame and compare every cycle against the computed waveform.
    task automatic run_tx(logic [7:0] data, bit f, bit mid_write, bit flip_speed,
                          bit with_rx, bit clr_at_end);
        int p, bad_dat, bad_clk, bad_oe, early;
        p = per_of(f);
        bad_dat = 0; bad_clk = 0; bad_oe = 0; early = 0;
        @(negedge clk);
        speed_fast_i = f; tx_data_i = data; tx_wr_i = 1'b1;
        if (with_rx) rx_en_i = 1'b1;
        @(negedge clk);
        tx_wr_i = 1'b0; rx_en_i = 1'b0; tx_data_i = ~data;
        for (int c = 0; c < 8 * p; c++) begin
            int ph, b;
            ph = c % p; b = c / p;
            if (sclk_o !== exp_sclk(ph, f)) bad_clk++;
            if (sdat_o !== data[b]) bad_dat++;
            if (sdat_oe_o !== 1'b1) bad_oe++;
            if (tx_done_o !== 1'b0) early++;
            tx_wr_i       = mid_write && (c == p + 2);
            speed_fast_i  = (flip_speed && c >= 5) ? ~f : f;
            tx_done_clr_i = clr_at_end && (c == 8 * p - 1);
            @(negedge clk);
        end
        tx_done_clr_i = 1'b0; tx_wr_i = 1'b0; speed_fast_i = f;
        check("R2 tx data bits", bad_dat, 0);
        check("R4 tx clock waveform", bad_clk, 0);
        check(with_rx ? "R8 tx priority enable" : "R2 tx enable", bad_oe, 0);
        check("R3 frame length (no early done)", early, 0);
        check(clr_at_end ? "R10 set wins over clear" : "R5 tx done", tx_done_o, 1);
        check("R5 enable dropped", sdat_oe_o, 0);
        check("R4 idle clock", sclk_o, 1);
        pulse_clear_tx();
    endtask

    // Receive one frame; the correct bit is present only in the cycle before each rise.
    task automatic run_rx(logic [7:0] pat, bit f, bit flip_speed);
        int p, s, bad_clk, bad_oe, blk;
        p = per_of(f); s = lead_of(f) + low_of(f) - 1;
        bad_clk = 0; bad_oe = 0; blk = 0;
        @(negedge clk);
        speed_fast_i = f; rx_en_i = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 8 * p; c++) begin
            int ph, b;
            ph = c % p; b = c / p;
            sdat_i = (ph == s) ? pat[b] : ~pat[b];
            if (sclk_o !== exp_sclk(ph, f)) bad_clk++;
            if (sdat_oe_o !== 1'b0) bad_oe++;
            speed_fast_i = (flip_speed && c >= 3) ? ~f : f;
            @(negedge clk);
        end
        speed_fast_i = f;
        check("R6 rx clock waveform", bad_clk, 0);
        check("R6 rx enable low", bad_oe, 0);
        check("R6 rx done", rx_done_o, 1);
        check("R6 rx byte", rx_data_o, pat);
        for (int c = 0; c < 2 * p; c++) begin
            if (sclk_o !== 1'b1 || sdat_oe_o !== 1'b0) blk++;
            @(negedge clk);
        end
        check("R7 no receive while done", blk, 0);
        rx_en_i = 1'b0;
        rx_done_clr_i = 1'b1;
        @(negedge clk); rx_done_clr_i = 1'b0;
        check("R10 rx clear", rx_done_o, 0);
        check("R6 buffer kept", rx_data_o, pat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clock", sclk_o, 1);
        check("R1 reset enable", sdat_oe_o, 0);
        check("R1 reset tx done", tx_done_o, 0);
        check("R1 reset rx done", rx_done_o, 0);
        check("R1 reset buffer", rx_data_o, 0);

        run_tx(8'hA5, 1'b0, 0, 0, 0, 0);
        run_tx(8'h3C, 1'b1, 0, 0, 0, 0);
        run_tx(8'h81, 1'b0, 1, 0, 0, 0);   // R9
        run_tx(8'h7E, 1'b1, 1, 1, 0, 0);   // R9, R3
        run_tx(8'h0F, 1'b0, 0, 1, 0, 0);   // R3
        run_tx(8'hC3, 1'b1, 0, 0, 1, 0);   // R8
        run_tx(8'h55, 1'b0, 0, 0, 0, 1);   // R10

        run_rx(8'h96, 1'b0, 0);
        run_rx(8'h01, 1'b1, 0);
        run_rx(8'h80, 1'b0, 1);            // R3

        for (int i = 0; i < 8; i++) begin
            logic [7:0] d;
            bit f;
            d = 8'($urandom);
            f = 1'($urandom);
            if (i % 2 == 0) run_tx(d, f, 1'($urandom), 1'($urandom), 0, 0);
            else            run_rx(d, f, 1'($urandom));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule